// File: doc/BRIEF.md
# Trigger Frame Word Packer

This block takes the per-channel trigger results of a sixteen-channel digitizer and turns them into a stream of packed channel words for a serial link. Each channel supplies a 20-bit energy sum, three timing bits that mark which 4 ns tick of the frame its threshold crossing fell in, and a hit flag that says whether it passed threshold. A frame is started by a one-cycle SYNC pulse. On that cycle the block captures every channel and formats each one into a word. The words then leave one per accepted handshake, in channel order.

Two word formats are supported, and the format input picks one. The narrow format carries a 5-bit slice of the sum above the timing bits, so each word is one byte. The wide format carries a 13-bit slice above the same timing bits, so each word is 16 bits. A slice-position input sets the lowest sum bit that is transmitted. If the sum has any bit set above the chosen slice, the sum field saturates to all ones instead of wrapping. The output uses a valid/ready handshake. A start-of-frame marker comes with the first word. An overrun pulse reports a new SYNC that cuts off a frame before all of its words were taken.

Top module: `trig_frame_packer`

## Requirements
- R1: While reset is held and after its release, word_valid_o, sof_o and overrun_o are 0. word_o is 0 whenever word_valid_o is 0.
- R2: word_valid_o rises in the cycle after sync_i is sampled high. The frame's 16 words leave in channel order 0 to 15, and each one advances on a clock edge where word_valid_o and word_ready_i are both high.
- R3: sof_o is high together with the channel 0 word of a frame and low for every other word.
- R4: Narrow format (wide_i = 0): word_o[7:3] carries the 5-bit sum field, word_o[2:0] carries the channel's timing bits ch_time_i[3c+2:3c] unchanged, and word_o[15:8] is 0.
- R5: Wide format (wide_i = 1): word_o[15:3] carries the 13-bit sum field and word_o[2:0] carries the channel's timing bits.
- R6: The sum field is the channel sum shifted right by slice_lo_i. If the shifted value does not fit in the field width, the field is all ones.
- R7: A channel whose hit flag ch_hit_i[c] is 0 sends an all-zero word, so both its sum field and its timing bits are 0.
- R8: Channel inputs, wide_i and slice_lo_i are captured on the SYNC cycle. Changes to them while a frame is streaming do not alter that frame's words.
- R9: While word_valid_o is high and word_ready_i is low, the next cycle keeps word_valid_o high and word_o unchanged.
- R10: A SYNC sampled while words of the current frame are still pending makes overrun_o high for exactly the following cycle. The new frame then starts again from channel 0. A SYNC sampled while the block is idle leaves overrun_o at 0.
- R11: After the channel 15 word is accepted, word_valid_o is 0 until the next SYNC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one 4 ns tick |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_i | input | 1 | Frame start pulse |
| wide_i | input | 1 | Format select: 0 gives an 8-bit word, 1 gives a 16-bit word |
| slice_lo_i | input | 5 | Lowest sum bit placed in the sum field |
| ch_sum_i | input | 320 | 20-bit sum per channel; channel c is at [20c+19:20c] |
| ch_time_i | input | 48 | 3 timing bits per channel; channel c is at [3c+2:3c] |
| ch_hit_i | input | 16 | Threshold-passed flag per channel |
| word_ready_i | input | 1 | Downstream accepts the current word |
| word_o | output | 16 | Packed channel word |
| word_valid_o | output | 1 | word_o holds a pending word |
| sof_o | output | 1 | Current word is the channel 0 word |
| overrun_o | output | 1 | One-cycle pulse: the previous frame was cut off |

## Verification
A table of single-channel cases tries the formatter with sums that fit the field exactly, sums that exceed it by a single bit, slices at the bottom and at the top of the sum, and hit flags that are cleared. These cases separate an off-by-one shift or saturation boundary from a correct one, in both formats. Whole frames with a different value on every channel expose ordering and start-marker errors. A frame whose inputs change after SYNC separates capture from pass-through. A frame with a broken ready pattern shows whether words are held or dropped. Finally, a SYNC issued mid-frame is compared with one issued while idle, which shows whether the overrun pulse is tied to words that are still pending.

// File: rtl/trig_frame_packer.sv
module trig_frame_packer #(
  parameter int NCH   = 16,
  parameter int SUM_W = 20,
  parameter int TW    = 3,
  parameter int OUT_W = 16,
  parameter int NSUM  = 5,
  localparam int IW   = $clog2(NCH),
  localparam int SELW = $clog2(SUM_W),
  localparam int WSUM = OUT_W - TW,
  localparam int NW   = NSUM + TW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sync_i,
  input  logic               wide_i,
  input  logic [SELW-1:0]    slice_lo_i,
  input  logic [NCH*SUM_W-1:0] ch_sum_i,
  input  logic [NCH*TW-1:0]  ch_time_i,
  input  logic [NCH-1:0]     ch_hit_i,
  input  logic               word_ready_i,
  output logic [OUT_W-1:0]   word_o,
  output logic               word_valid_o,
  output logic               sof_o,
  output logic               overrun_o
);

  localparam logic [IW-1:0] LAST = IW'(NCH - 1);

  function automatic logic [OUT_W-1:0] pack(input logic wide, input logic [SELW-1:0] lo,
                                            input logic [SUM_W-1:0] s, input logic [TW-1:0] t,
                                            input logic hit);
    logic [SUM_W-1:0] sh;
    logic [WSUM-1:0]  fw;
    logic [NSUM-1:0]  fn;
    sh = s >> lo;
    fw = (|(sh >> WSUM)) ? {WSUM{1'b1}} : sh[WSUM-1:0];
    fn = (|(sh >> NSUM)) ? {NSUM{1'b1}} : sh[NSUM-1:0];
    if (!hit)     pack = '0;
    else if (wide) pack = {fw, t};
    else          pack = {{(OUT_W-NW){1'b0}}, fn, t};
  endfunction

  logic [OUT_W-1:0] frame_q [NCH];
  logic [IW-1:0]    idx_q;
  logic             busy_q, ovr_q;

  wire take = busy_q && word_ready_i;
  wire last = take && (idx_q == LAST);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    always_ff @(posedge clk)
      if (sync_i)
        frame_q[g] <= pack(wide_i, slice_lo_i, ch_sum_i[g*SUM_W +: SUM_W],
                           ch_time_i[g*TW +: TW], ch_hit_i[g]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      ovr_q  <= 1'b0;
    end else begin
      ovr_q <= sync_i && busy_q && !last;
      if (sync_i) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
      end else if (take) begin
        if (idx_q == LAST) busy_q <= 1'b0;
        else               idx_q  <= idx_q + 1'b1;
      end
    end
  end

  assign word_valid_o = busy_q;
  assign word_o       = busy_q ? frame_q[idx_q] : '0;
  assign sof_o        = busy_q && (idx_q == '0);
  assign overrun_o    = ovr_q;

endmodule

// File: rtl/trig_frame_packer_chk.sv
module trig_frame_packer_chk #(
  parameter int OUT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sync_i,
  input logic             word_ready_i,
  input logic [OUT_W-1:0] word_o,
  input logic             word_valid_o,
  input logic             sof_o,
  input logic             overrun_o
);

  a_r1_idle_word_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !word_valid_o |-> (word_o == '0) && !sof_o);

  a_r2_valid_after_sync: assert property (@(posedge clk) disable iff (!rst_n)
    sync_i |=> word_valid_o);

  a_r3_sof_leaves: assert property (@(posedge clk) disable iff (!rst_n)
    sof_o && word_ready_i && !sync_i |=> !sof_o);

  a_r3_sof_after_sync: assert property (@(posedge clk) disable iff (!rst_n)
    sync_i |=> sof_o);

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid_o && !word_ready_i && !sync_i |=> word_valid_o && $stable(word_o));

  a_r10_overrun_cause: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_o |-> $past(sync_i) && $past(word_valid_o));

  a_r10_overrun_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_o |=> !overrun_o || $past(sync_i));

  a_r10_idle_sync: assert property (@(posedge clk) disable iff (!rst_n)
    sync_i && !word_valid_o |=> !overrun_o);

endmodule

bind trig_frame_packer trig_frame_packer_chk #(.OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .word_ready_i(word_ready_i),
  .word_o(word_o), .word_valid_o(word_valid_o), .sof_o(sof_o), .overrun_o(overrun_o)
);

// File: tb/trig_frame_packer_test.sv
`timescale 1ns/1ps
module trig_frame_packer_test;
  localparam int NCH = 16, SW = 20, TW = 3;

  logic clk = 1'b0, rst_n = 1'b0, sync_i = 1'b0, wide_i = 1'b0, word_ready_i = 1'b0;
  logic [4:0] slice_lo_i = '0;
  logic [SW-1:0] s_in [NCH];
  logic [TW-1:0] t_in [NCH];
  logic [NCH-1:0] ch_hit_i = '0;
  logic [NCH*SW-1:0] ch_sum_i;
  logic [NCH*TW-1:0] ch_time_i;
  logic [15:0] word_o;
  logic word_valid_o, sof_o, overrun_o;

  int errors = 0, checks = 0;
  logic [15:0] exp_w [NCH];

  always #2 clk = ~clk;

  always_comb
    for (int i = 0; i < NCH; i++) begin
      ch_sum_i[i*SW +: SW]  = s_in[i];
      ch_time_i[i*TW +: TW] = t_in[i];
    end

  trig_frame_packer uut (
    .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .wide_i(wide_i), .slice_lo_i(slice_lo_i),
    .ch_sum_i(ch_sum_i), .ch_time_i(ch_time_i), .ch_hit_i(ch_hit_i),
    .word_ready_i(word_ready_i), .word_o(word_o), .word_valid_o(word_valid_o),
    .sof_o(sof_o), .overrun_o(overrun_o)
  );

  localparam int NT = 10;
  localparam bit         T_WIDE [NT] = '{0, 0, 0, 0, 0, 1, 1, 1, 1, 0};
  localparam int         T_LO   [NT] = '{0, 4, 4, 15, 0, 0, 7, 6, 19, 1};
  localparam logic [19:0] T_SUM [NT] = '{20'h00015, 20'h001F0, 20'h00200, 20'hA8000, 20'hFFFFF,
                                         20'h01234, 20'hFFFFF, 20'hFFFFF, 20'h80000, 20'h0003F};
  localparam int         T_TIM  [NT] = '{5, 3, 0, 7, 7, 2, 1, 0, 4, 6};
  localparam bit         T_HIT  [NT] = '{1, 1, 1, 1, 0, 1, 1, 1, 1, 1};
  localparam logic [15:0] T_EXP [NT] = '{16'h00AD, 16'h00FB, 16'h00F8, 16'h00AF, 16'h0000,
                                         16'h91A2, 16'hFFF9, 16'hFFF8, 16'h000C, 16'h00FE};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [15:0] model(input bit wide, input int lo, input logic [19:0] s,
                                        input int t, input bit hit);
    longint v, maxv;
    v = longint'(s) / (longint'(1) << lo);
    maxv = wide ? 8191 : 31;
    if (v > maxv) v = maxv;
    return hit ? 16'(v * 8 + t) : 16'h0;
  endfunction

  task automatic fill_exp();
    for (int i = 0; i < NCH; i++)
      exp_w[i] = model(wide_i, int'(slice_lo_i), s_in[i], int'(t_in[i]), ch_hit_i[i]);
  endtask

  task automatic load_pattern(input int seed, input bit wide, input int lo);
    wide_i = wide;
    slice_lo_i = 5'(lo);
    for (int i = 0; i < NCH; i++) begin
      s_in[i] = 20'((i + 1) * 20'h0AB37) ^ 20'(seed);
      t_in[i] = 3'(i + seed);
      ch_hit_i[i] = ((i + seed) % 5) != 3;
    end
  endtask

  // mode 0: ready always high; mode 1: ready low every third cycle. alter: change inputs after SYNC.
  task automatic run_frame(input int mode, input bit alter, input string req);
    int cnt = 0, cyc = 0;
    bit held = 0;
    logic [15:0] hw = '0;
    fill_exp();
    @(negedge clk) sync_i = 1'b1;
    @(negedge clk) sync_i = 1'b0;
    if (alter) load_pattern(77, ~wide_i, 2);
    while (cnt < NCH && cyc < 200) begin
      if (held) chk("R9 hold", {word_valid_o, word_o}, {1'b1, hw});
      word_ready_i = (mode == 0) ? 1'b1 : ((cyc % 3) != 2);
      held = word_valid_o && !word_ready_i;
      hw = word_o;
      if (word_valid_o && word_ready_i) begin
        chk({req, " word"}, word_o, exp_w[cnt]);
        chk("R3 sof", sof_o, cnt == 0);
        cnt++;
      end
      @(negedge clk);
      cyc++;
    end
    chk("R2 all words", cnt, NCH);
    chk("R11 valid drops", word_valid_o, 0);
    chk("R1 idle word zero", word_o, 0);
  endtask

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < NCH; i++) begin s_in[i] = '0; t_in[i] = '0; end
    repeat (3) @(negedge clk);
    chk("R1 reset valid", word_valid_o, 0);
    chk("R1 reset sof", sof_o, 0);
    chk("R1 reset overrun", overrun_o, 0);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset valid", word_valid_o, 0);
    chk("R1 after reset word", word_o, 0);

    // R4 R5 R6 R7: table of single-channel formatting cases
    for (int k = 0; k < NT; k++) begin
      for (int i = 0; i < NCH; i++) begin s_in[i] = 20'hFFFFF; t_in[i] = 3'd7; end
      ch_hit_i = '0;
      wide_i = T_WIDE[k];
      slice_lo_i = 5'(T_LO[k]);
      s_in[0] = T_SUM[k];
      t_in[0] = 3'(T_TIM[k]);
      ch_hit_i[0] = T_HIT[k];
      fill_exp();
      chk("R4 R5 R6 R7 table model", exp_w[0], T_EXP[k]);
      run_frame(0, 0, T_WIDE[k] ? "R5 R6 R7" : "R4 R6 R7");
    end

    load_pattern(5, 1, 3);  run_frame(0, 0, "R2 R5 order");
    load_pattern(9, 0, 9);  run_frame(0, 0, "R2 R4 order");
    load_pattern(3, 1, 0);  run_frame(0, 1, "R8 capture");
    load_pattern(12, 0, 6); run_frame(1, 0, "R9 backpressure");

    // R10: SYNC while words pending
    load_pattern(21, 1, 4);
    word_ready_i = 1'b1;
    @(negedge clk) sync_i = 1'b1;
    @(negedge clk) sync_i = 1'b0;
    repeat (4) @(negedge clk);
    chk("R10 no overrun mid-frame", overrun_o, 0);
    load_pattern(40, 0, 7);
    fill_exp();
    sync_i = 1'b1;
    @(negedge clk) sync_i = 1'b0;
    chk("R10 overrun pulse", overrun_o, 1);
    chk("R10 restart sof", sof_o, 1);
    chk("R10 restart word", word_o, exp_w[0]);
    @(negedge clk);
    chk("R10 overrun one cycle", overrun_o, 0);
    repeat (20) @(negedge clk);
    chk("R11 drained", word_valid_o, 0);
    sync_i = 1'b1;
    @(negedge clk) sync_i = 1'b0;
    chk("R10 idle sync no overrun", overrun_o, 0);
    chk("R2 valid after sync", word_valid_o, 1);
    repeat (20) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule